// File: doc/BRIEF.md
# Link Frame Receiver with CRC Check

This block sits on the receive side of a serial storage link. It takes a stream of 32-bit dwords, each flagged as a control primitive or as data. It waits for the sender to announce a frame, answers that announcement, and then collects the payload dwords that lie between the start marker and the end marker. A CRC-32 is kept over the payload. The last data dword before the end marker carries the CRC and is checked against the running value. That dword is not delivered. The other payload dwords leave on a valid/ready stream. The final payload entry carries a last flag and the frame's error verdict.

On the back channel the block reports its status as a 3-bit code. It sends ready once a frame is announced and in-progress while the frame is received. After the end marker it sends good or error. It answers a sender pause with an acknowledge. When its output FIFO fills past a high-water mark, it sends its own pause. The mark is placed so that the FIFO can absorb the dwords the sender may still send after the pause is raised.

Top module: `link_frame_rx`

## Requirements
- R1: After a synchronous active-low reset, `bc_code` is SYNC (0) and `out_valid` is 0.
- R2: In idle, a received X_RDY primitive (code 0x02 in `rx_dword[7:0]` with `rx_is_prim`=1) makes `bc_code` R_RDY (1) one cycle later. A following SOF primitive (0x03) makes it R_IP (2), and R_IP holds while data dwords arrive.
- R3: Every data dword of a frame except the last one before EOF (0x04) is output in arrival order. The final one is output with `out_last`=1, and `out_err` is 0 on all other entries.
- R4: The CRC runs MSB first over every payload dword before the CRC dword. It uses generator 0x04C11DB7, starts from seed 0x52325032, and has no reflection and no final inversion. A mismatch sets `out_err` on the last entry and makes the status R_ERR (4) instead of R_OK (3).
- R5: Bits [7:0] of the first payload dword are the frame type. Any value outside {0x27, 0x34, 0x39, 0x41, 0x46, 0x58, 0x5F, 0xA1} marks the frame as an error.
- R6: A frame of more than 2064 data dwords (CRC dword included) is an error. A frame of exactly 2064 is not.
- R7: A HOLD primitive (0x05) received inside a frame is not counted as payload. While the FIFO is below its mark, it makes `bc_code` HOLDA (6) one cycle later.
- R8: When the FIFO level reaches DEPTH-SKID-2, `bc_code` becomes HOLD (5). If the sender sends at most 20 more data dwords after seeing HOLD, no payload is lost.
- R9: If the FIFO is above its mark in the same cycle that a sender HOLD arrives, `bc_code` is HOLD, not HOLDA.
- R10: After EOF the status code stays unchanged until a SYNC primitive (0x01) arrives, which returns `bc_code` to SYNC.
- R11: A frame with fewer than two data dwords produces a single entry with data 0, `out_last`=1 and `out_err`=1, and the status R_ERR.
- R12: Data dwords received outside a frame produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dword | input | 32 | Received dword; primitive code in bits [7:0] when flagged |
| rx_is_prim | input | 1 | 1 = dword is a primitive, 0 = data |
| bc_code | output | 3 | Back-channel status primitive code |
| out_data | output | 32 | Payload dword |
| out_last | output | 1 | Final payload entry of a frame |
| out_err | output | 1 | Frame error verdict, valid with out_last |
| out_valid | output | 1 | Output entry available |
| out_ready | input | 1 | Consumer accepts the entry |

## Verification
The back-channel encoder can be asked for two answers in one cycle: a sender pause that calls for an acknowledge, and a FIFO above its mark that calls for the block's own pause. The bench provokes this by stalling the consumer until a dozen payload dwords are queued and then sending a HOLD primitive. It expects HOLD, not HOLDA, on the back channel. It then releases the consumer and repeats the HOLD until HOLDA appears. The payload of that frame is compared entry by entry, which shows that neither the skipped HOLDs nor the skid dwords were lost.

// File: rtl/lfr_pkg.sv
// Shared codes and types for the link frame receiver.
// Assumes primitive codes arrive in bits [7:0] of a dword flagged as primitive.
package lfr_pkg;

    localparam logic [7:0] PRIM_SYNC  = 8'h01;
    localparam logic [7:0] PRIM_XRDY  = 8'h02;
    localparam logic [7:0] PRIM_SOF   = 8'h03;
    localparam logic [7:0] PRIM_EOF   = 8'h04;
    localparam logic [7:0] PRIM_HOLD  = 8'h05;
    localparam logic [7:0] PRIM_HOLDA = 8'h06;
    localparam logic [7:0] PRIM_WTRM  = 8'h07;

    typedef enum logic [2:0] {
        BC_SYNC  = 3'd0,
        BC_RRDY  = 3'd1,
        BC_RIP   = 3'd2,
        BC_ROK   = 3'd3,
        BC_RERR  = 3'd4,
        BC_HOLD  = 3'd5,
        BC_HOLDA = 3'd6
    } bc_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READY,
        ST_RECV,
        ST_STATUS
    } rx_state_e;

    typedef struct packed {
        logic [31:0] data;
        logic        last;
        logic        err;
    } out_entry_t;

    // Tells whether a frame type byte is one of the known types.
    function automatic logic frame_type_known(input logic [7:0] t);
        case (t)
            8'h27, 8'h34, 8'h39, 8'h41, 8'h46, 8'h58, 8'h5F, 8'hA1: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/link_rx_crc.sv
// Running CRC-32 register, MSB first, no reflection, no output inversion.
// Assumes clear and enable are never both high; clear wins if they are.
module link_rx_crc #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] POLY  = 32'h04C11DB7,
    parameter logic [31:0] SEED  = 32'h52325032
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [WIDTH-1:0] din,
    output logic [31:0]      crc
);

    logic [31:0] crc_next;

    // Folds one input word into the current remainder, one bit at a time.
    always_comb begin
        logic fb;
        crc_next = crc;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            fb       = crc_next[31] ^ din[i];
            crc_next = {crc_next[30:0], 1'b0};
            if (fb) crc_next = crc_next ^ POLY;
        end
    end

    // Holds the remainder; reloads the seed at reset or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc <= SEED;
        else if (clear)  crc <= SEED;
        else if (enable) crc <= crc_next;
    end

    // R4: a clear always leaves the seed in place for the next frame
    p_clear_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == SEED));

endmodule

// File: rtl/link_rx_fifo.sv
// Synchronous FIFO for output entries with a level count.
// Assumes DEPTH is a power of two and the writer respects the level.
module link_rx_fifo
    import lfr_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  out_entry_t         push_entry,
    input  logic               pop_ready,
    output logic               pop_valid,
    output out_entry_t         pop_entry,
    output logic [LEVEL_W-1:0] level
);

    localparam int AW = $clog2(DEPTH);

    out_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          pop;

    assign pop_valid = (level != '0);
    assign pop_entry = mem[rd_ptr];
    assign pop       = pop_valid && pop_ready;

    // Writes the storage array on a push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_entry;
    end

    // Advances the pointers and tracks the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R8: the pause mark leaves room, so a push never meets a full FIFO
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level < LEVEL_W'(DEPTH)));

endmodule

// File: rtl/link_rx_frame.sv
// Frame tracker: handshake state, two-dword holdback, length and type checks,
// FIFO push generation and back-channel code selection.
// Assumes the CRC unit reflects crc_en one cycle later and the FIFO level is current.
module link_rx_frame
    import lfr_pkg::*;
#(
    parameter int MAX_DW  = 2064,
    parameter int DEPTH   = 32,
    parameter int SKID    = 20,
    parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        rx_dword,
    input  logic               rx_is_prim,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic [31:0]        crc_val,
    output logic               crc_clear,
    output logic               crc_en,
    output logic [31:0]        crc_din,
    output logic               push,
    output out_entry_t         push_entry,
    output bc_code_e           bc_code
);

    localparam int CNT_W     = $clog2(MAX_DW + 2);
    localparam int HIGH_MARK = DEPTH - SKID - 2;

    rx_state_e        state_q, state_d;
    logic [31:0]      h0_q, h1_q;
    logic             h0_v, h1_v;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             stat_err_q;
    logic             stat_err_d;
    bc_code_e         bc_d;

    logic is_data, prim_xrdy, prim_sof, prim_eof, prim_hold, prim_sync;
    logic level_hi, eof_bad, in_recv;

    assign is_data   = !rx_is_prim;
    assign prim_xrdy = rx_is_prim && (rx_dword[7:0] == PRIM_XRDY);
    assign prim_sof  = rx_is_prim && (rx_dword[7:0] == PRIM_SOF);
    assign prim_eof  = rx_is_prim && (rx_dword[7:0] == PRIM_EOF);
    assign prim_hold = rx_is_prim && (rx_dword[7:0] == PRIM_HOLD);
    assign prim_sync = rx_is_prim && (rx_dword[7:0] == PRIM_SYNC);
    assign in_recv   = (state_q == ST_RECV);
    assign level_hi  = (fifo_level >= LEVEL_W'(HIGH_MARK));
    assign eof_bad   = err_q || !h0_v || !h1_v || (crc_val != h0_q);

    // Selects the next handshake state from the received primitive.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (prim_xrdy) state_d = ST_READY;
            ST_READY:  if (prim_sof) state_d = ST_RECV;
                       else if (prim_sync) state_d = ST_IDLE;
            ST_RECV:   if (prim_eof) state_d = ST_STATUS;
            ST_STATUS: if (prim_sync) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Drives the CRC unit and the FIFO push from the holdback registers.
    always_comb begin
        crc_clear  = (state_q == ST_READY) && prim_sof;
        crc_en     = in_recv && is_data && h0_v;
        crc_din    = h0_q;
        push       = 1'b0;
        push_entry = '{data: h1_q, last: 1'b0, err: 1'b0};
        if (in_recv && is_data && h1_v) begin
            push = 1'b1;
        end else if (in_recv && prim_eof) begin
            push       = 1'b1;
            push_entry = '{data: (h1_v ? h1_q : 32'h0), last: 1'b1, err: eof_bad};
        end
    end

    // Picks the back-channel code for the state entered at this edge.
    always_comb begin
        stat_err_d = in_recv ? eof_bad : stat_err_q;
        case (state_d)
            ST_IDLE:   bc_d = BC_SYNC;
            ST_READY:  bc_d = BC_RRDY;
            ST_RECV:   bc_d = level_hi ? BC_HOLD : (prim_hold ? BC_HOLDA : BC_RIP);
            ST_STATUS: bc_d = stat_err_d ? BC_RERR : BC_ROK;
            default:   bc_d = BC_SYNC;
        endcase
    end

    // Registers the state and the back-channel code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bc_code <= BC_SYNC;
        end else begin
            state_q <= state_d;
            bc_code <= bc_d;
        end
    end

    // Shifts data through the holdback pair and accumulates frame errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h0_q       <= '0;
            h1_q       <= '0;
            h0_v       <= 1'b0;
            h1_v       <= 1'b0;
            cnt_q      <= '0;
            err_q      <= 1'b0;
            stat_err_q <= 1'b0;
        end else if (crc_clear) begin
            h0_v  <= 1'b0;
            h1_v  <= 1'b0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (in_recv && is_data) begin
            h0_q <= rx_dword;
            h0_v <= 1'b1;
            if (h0_v) begin
                h1_q <= h0_q;
                h1_v <= 1'b1;
            end
            if (cnt_q <= CNT_W'(MAX_DW)) cnt_q <= cnt_q + 1'b1;
            err_q <= err_q
                   || ((cnt_q == '0) && !frame_type_known(rx_dword[7:0]))
                   || (cnt_q >= CNT_W'(MAX_DW));
        end else if (in_recv && prim_eof) begin
            stat_err_q <= eof_bad;
        end
    end

    // R2: an announced frame is answered with receiver-ready
    p_answer_xrdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && prim_xrdy) |=> (bc_code == BC_RRDY));

    // R7: a sender pause with room in the FIFO is acknowledged
    p_holda_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recv && prim_hold && !level_hi) |=> (bc_code == BC_HOLDA));

    // R9: the own pause takes priority over the acknowledge
    p_hold_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recv && !prim_eof && level_hi) |=> (bc_code == BC_HOLD));

    // R10: the status code stays put until the sender returns to SYNC
    p_status_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STATUS && !prim_sync) |=> $stable(bc_code));

    // R3: only the last entry of a frame may carry the error flag
    p_err_only_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !push_entry.last) |-> !push_entry.err);

    // R6: a data dword past the length limit leaves the frame in error
    p_len_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recv && is_data && cnt_q >= CNT_W'(MAX_DW)) |=> err_q);

endmodule

// File: rtl/link_frame_rx.sv
// Top of the link frame receiver: ties the frame tracker, CRC unit and output FIFO.
// Assumes the sender stops data within SKID dwords of seeing HOLD.
module link_frame_rx
    import lfr_pkg::*;
#(
    parameter int MAX_DW = 2064,
    parameter int DEPTH  = 32,
    parameter int SKID   = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] rx_dword,
    input  logic        rx_is_prim,
    output logic [2:0]  bc_code,
    output logic [31:0] out_data,
    output logic        out_last,
    output logic        out_err,
    output logic        out_valid,
    input  logic        out_ready
);

    localparam int LEVEL_W = $clog2(DEPTH + 1);

    logic [LEVEL_W-1:0] fifo_level;
    logic [31:0]        crc_val, crc_din;
    logic               crc_clear, crc_en, push;
    out_entry_t         push_entry, pop_entry;
    bc_code_e           bc_int;

    link_rx_frame #(
        .MAX_DW (MAX_DW),
        .DEPTH  (DEPTH),
        .SKID   (SKID),
        .LEVEL_W(LEVEL_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_dword  (rx_dword),
        .rx_is_prim(rx_is_prim),
        .fifo_level(fifo_level),
        .crc_val   (crc_val),
        .crc_clear (crc_clear),
        .crc_en    (crc_en),
        .crc_din   (crc_din),
        .push      (push),
        .push_entry(push_entry),
        .bc_code   (bc_int)
    );

    link_rx_crc #(
        .WIDTH(32)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .enable(crc_en),
        .din   (crc_din),
        .crc   (crc_val)
    );

    link_rx_fifo #(
        .DEPTH  (DEPTH),
        .LEVEL_W(LEVEL_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_entry(push_entry),
        .pop_ready (out_ready),
        .pop_valid (out_valid),
        .pop_entry (pop_entry),
        .level     (fifo_level)
    );

    assign bc_code  = bc_int;
    assign out_data = pop_entry.data;
    assign out_last = pop_entry.last;
    assign out_err  = pop_entry.err;

    // R1: the back channel sits at SYNC while nothing is announced
    p_reset_sync_r1: assert property (@(posedge clk)
        !rst_n |=> (bc_code == 3'd0 && !out_valid));

endmodule

// File: tb/tb_link_frame_rx.sv
// Scoreboard bench: frame tasks queue expected entries, a monitor pops and compares.
module tb_link_frame_rx;
    import lfr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_DW     = 2064;
    localparam int SKID       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_dword = {24'h0, PRIM_SYNC};
    logic        rx_is_prim = 1'b1;
    logic [2:0]  bc_code;
    logic [31:0] out_data;
    logic        out_last, out_err, out_valid;
    logic        out_ready = 1'b1;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  hold_seen = 0;
    logic [33:0] exp_q[$];

    link_frame_rx #(.MAX_DW(MAX_DW), .DEPTH(32), .SKID(SKID)) dut (
        .clk(clk), .rst_n(rst_n), .rx_dword(rx_dword), .rx_is_prim(rx_is_prim),
        .bc_code(bc_code), .out_data(out_data), .out_last(out_last),
        .out_err(out_err), .out_valid(out_valid), .out_ready(out_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Counts one comparison and reports a mismatch.
    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one dword for one clock; returns just after the capturing edge.
    task automatic send(input bit prim, input logic [31:0] v);
        rx_is_prim = prim;
        rx_dword   = v;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d);
        logic fb;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    function automatic bit type_ok(input logic [7:0] t);
        logic [7:0] known[8] = '{8'hA1, 8'h5F, 8'h27, 8'h46, 8'h39, 8'h34, 8'h58, 8'h41};
        foreach (known[k]) if (known[k] == t) return 1;
        return 0;
    endfunction

    // Sends a full frame of n payload dwords plus CRC and checks the back channel.
    task automatic send_frame(input int n, input logic [7:0] ftype, input bit corrupt,
                              input int hold_at, input bit obey, input bit expect_ip,
                              input string tag);
        logic [31:0] p[$];
        logic [31:0] crc = 32'h52325032;
        logic [31:0] w;
        bit e;
        int skid = 0;
        for (int i = 0; i < n; i++) begin
            w = (i == 0) ? {8'hC3, 8'(n), 8'h11, ftype} : (32'h9E3779B9 * (i + 1)) ^ i;
            p.push_back(w);
            crc = crc_upd(crc, w);
        end
        e = corrupt || !type_ok(ftype) || (n + 1 > MAX_DW) || (n < 1);
        if (n == 0) exp_q.push_back({32'h0, 1'b1, 1'b1});
        for (int i = 0; i < n; i++)
            exp_q.push_back({p[i], (i == n - 1), (i == n - 1) ? e : 1'b0});
        send(1, {24'h0, PRIM_XRDY});
        check(bc_code == BC_RRDY, "R2 R_RDY after X_RDY", bc_code, BC_RRDY);
        send(1, {24'h0, PRIM_SOF});
        if (expect_ip) check(bc_code == BC_RIP, "R2 R_IP after SOF", bc_code, BC_RIP);
        for (int i = 0; i <= n; i++) begin
            if (obey) begin
                while (bc_code == BC_HOLD && skid >= SKID) begin
                    hold_seen = 1;
                    send(1, {24'h0, PRIM_HOLDA});
                end
                if (bc_code != BC_HOLD) skid = 0;
                else begin
                    skid++;
                    hold_seen = 1;
                end
            end
            if (i == hold_at) begin
                for (int k = 0; k < 3; k++) begin
                    send(1, {24'h0, PRIM_HOLD});
                    check(bc_code == BC_HOLDA, "R7 HOLDA for sender HOLD", bc_code, BC_HOLDA);
                end
            end
            w = (i < n) ? p[i] : (corrupt ? (crc ^ 32'h1) : crc);
            send(0, w);
            if (expect_ip && i < 6) check(bc_code == BC_RIP, "R2 R_IP during data", bc_code, BC_RIP);
        end
        send(1, {24'h0, PRIM_EOF});
        check(bc_code == (e ? BC_RERR : BC_ROK), tag, bc_code, e ? BC_RERR : BC_ROK);
        for (int k = 0; k < 3; k++) send(1, {24'h0, PRIM_WTRM});
        check(bc_code == (e ? BC_RERR : BC_ROK), "R10 status held in WTRM", bc_code,
              e ? BC_RERR : BC_ROK);
        send(1, {24'h0, PRIM_SYNC});
        check(bc_code == BC_SYNC, "R10 SYNC after status", bc_code, BC_SYNC);
    endtask

    // Monitor: compares every accepted output entry with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R3/R12 unexpected output entry", {out_data, out_last, out_err}, 0);
            end else begin
                logic [33:0] ex;
                ex = exp_q.pop_front();
                check({out_data, out_last, out_err} == ex, "R3/R4 output entry",
                      {out_data, out_last, out_err}, ex);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        check(0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check(bc_code == BC_SYNC && !out_valid, "R1 reset state", {bc_code, out_valid}, 0);

        // R12: data outside a frame is dropped
        for (int k = 0; k < 3; k++) send(0, 32'hDEAD0000 + k);
        send(1, {24'h0, PRIM_SYNC});
        check(!out_valid && bc_code == BC_SYNC, "R12 idle data ignored", out_valid, 0);

        send_frame(4, 8'h27, 0, -1, 0, 1, "R4 good CRC gives R_OK");
        send_frame(5, 8'h39, 1, -1, 0, 1, "R4 bad CRC gives R_ERR");
        send_frame(3, 8'h99, 0, -1, 0, 1, "R5 unknown type gives R_ERR");
        send_frame(3, 8'hA1, 0, -1, 0, 1, "R5 known type gives R_OK");
        send_frame(6, 8'h58, 0, 2, 0, 1, "R7 frame with HOLD gives R_OK");
        send_frame(0, 8'h27, 0, -1, 0, 1, "R11 short frame gives R_ERR");
        send_frame(MAX_DW - 1, 8'h41, 0, -1, 0, 1, "R6 frame at limit gives R_OK");
        send_frame(MAX_DW, 8'h41, 0, -1, 0, 1, "R6 frame over limit gives R_ERR");

        // R9: own pause and sender pause in the same cycle
        begin
            logic [31:0] crc = 32'h52325032;
            logic [31:0] w;
            out_ready = 1'b0;
            send(1, {24'h0, PRIM_XRDY});
            send(1, {24'h0, PRIM_SOF});
            for (int i = 0; i < 14; i++) begin
                w = (i == 0) ? 32'h00AB0034 : 32'h1000 + i;
                crc = crc_upd(crc, w);
                exp_q.push_back({w, (i == 13), 1'b0});
                send(0, w);
            end
            check(bc_code == BC_HOLD, "R8 HOLD at high-water mark", bc_code, BC_HOLD);
            send(1, {24'h0, PRIM_HOLD});
            check(bc_code == BC_HOLD, "R9 HOLD wins over HOLDA", bc_code, BC_HOLD);
            out_ready = 1'b1;
            for (int k = 0; k < 20; k++) send(1, {24'h0, PRIM_HOLD});
            check(bc_code == BC_HOLDA, "R7 HOLDA once drained", bc_code, BC_HOLDA);
            send(0, crc);
            send(1, {24'h0, PRIM_EOF});
            check(bc_code == BC_ROK, "R9 frame intact gives R_OK", bc_code, BC_ROK);
            send(1, {24'h0, PRIM_SYNC});
        end

        // R8: sustained stall with a sender that obeys HOLD within its skid
        hold_seen = 0;
        fork
            send_frame(60, 8'h46, 0, -1, 1, 0, "R8 stalled frame gives R_OK");
            begin
                out_ready = 1'b0;
                repeat (100) @(posedge clk);
                #1 out_ready = 1'b1;
            end
        join
        check(hold_seen, "R8 HOLD seen under stall", hold_seen, 1);

        repeat (200) begin
            if (exp_q.size() != 0) @(posedge clk);
        end
        #1;
        check(exp_q.size() == 0, "R3 all entries delivered", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule